// File: doc/BRIEF.md
# Disk Controller Command Sequencer

This block is the front end of a disk controller's command engine. A host writes a command code byte and then any argument bytes through a byte-wide data port. Between bytes the host polls a status byte: a ready flag says a byte may move, and a direction flag says which way. The sequencer works out from the command code how many argument bytes must follow. It takes them strictly in order and then hands the complete command to an execution-phase controller.

Each accepted byte takes a fixed processing time. The ready flag stays low for that time and comes back only if another argument byte is due. An unrecognised code goes straight to the result phase with a single status byte. The data FIFO enable is forced off everywhere except the execution phase. The host ends each command by reading one result byte, which returns the block to the command phase.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After asynchronous reset, msr_o reads 0x80, exec_start_o is 0 and fifo_en_o is 0.
- R2: msr_o encoding: bit 7 is RQM (host may move a byte), bit 6 is DIO (1 = result byte toward host), bit 4 is busy (set in every state except idle command wait). All other bits read 0. The execution phase reads 0x10 and the result phase reads 0xD0.
- R3: A write on wr_en_i is taken only while RQM=1 and DIO=0. A write at any other time changes neither the stored bytes nor the phase.
- R4: After an accepted write, RQM reads 0 for exactly PROC_CYC (default 2) cycles. It then returns to 1 if another argument byte is due.
- R5: The argument count is looked up on code bits [4:0]. The counts are: 0x03→2, 0x04→1, 0x05→8, 0x06→8, 0x07→1, 0x08→0, 0x0A→1, 0x0E→0, 0x0F→2, 0x13→3. Every other value is invalid.
- R6: An invalid code makes the block enter the result phase (msr_o=0xD0) with rd_data_o=0x80 after processing. No execution handoff takes place.
- R7: After the last argument byte is processed, RQM stays 0 and exec_start_o pulses for one cycle. exec_opcode_o then holds the code byte and exec_nparam_o holds the count. Argument k (from 0) appears at exec_param_o[8k+7:8k].
- R8: A code with zero arguments enters the execution phase right after processing, and RQM never returns to 1 in between.
- R9: fifo_en_o equals fifo_cfg_i in the execution phase and is 0 in every other phase.
- R10: exec_done_i in the execution phase moves the block to the result phase, with rd_data_o equal to exec_status_i as sampled on that cycle. rd_en_i in the result phase returns the block to the command phase (msr_o=0x80).
- R11: soft_rst_i, sampled on a clock edge, returns the block to the command phase with the argument counter cleared (msr_o=0x80 on the next cycle).
- R12: Code bits [7:5] carry modifiers and do not affect the argument count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous return to command phase |
| wr_en_i | input | 1 | Host write strobe for data port |
| wr_data_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Host read strobe for result byte |
| rd_data_o | output | 8 | Result byte |
| msr_o | output | 8 | Main status byte (RQM, DIO, busy) |
| fifo_cfg_i | input | 1 | FIFO enable as configured |
| fifo_en_o | output | 1 | Effective FIFO enable |
| exec_start_o | output | 1 | One-cycle handoff pulse to execution controller |
| exec_opcode_o | output | 8 | Captured command code byte |
| exec_nparam_o | output | 4 | Number of argument bytes captured |
| exec_param_o | output | 64 | Captured argument bytes, byte k at [8k+7:8k] |
| exec_done_i | input | 1 | Execution controller finished |
| exec_status_i | input | 8 | Status byte from execution controller |

## Verification
The assertions assume a host that obeys the handshake. They also assume soft_rst_i does not arrive in the PROC_CYC cycles after an accepted write, since otherwise the RQM-low window would be cut short. The stimulus raises soft_rst_i only while the block waits in a ready state. It does drive writes that the handshake forbids, during processing and in the result phase, but only to confirm that these writes are ignored. exec_done_i is raised only in the execution phase, and rd_en_i only once the result phase is reached.

// File: rtl/fdc_cmd_pkg.sv
package fdc_cmd_pkg;
  typedef enum logic [2:0] {
    PH_CMD    = 3'd0,
    PH_PROC   = 3'd1,
    PH_PARAM  = 3'd2,
    PH_EXEC   = 3'd3,
    PH_RESULT = 3'd4
  } phase_e;

  localparam logic [7:0] BAD_CMD_STATUS = 8'h80;
  localparam int unsigned OPC_W = 5;
endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_cmd_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic [OPC_W-1:0] code_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);
  always_comb begin
    valid_o = 1'b1;
    count_o = '0;
    unique case (code_i)
      5'h03: count_o = CNT_W'(2);
      5'h04: count_o = CNT_W'(1);
      5'h05: count_o = CNT_W'(8);
      5'h06: count_o = CNT_W'(8);
      5'h07: count_o = CNT_W'(1);
      5'h08: count_o = CNT_W'(0);
      5'h0A: count_o = CNT_W'(1);
      5'h0E: count_o = CNT_W'(0);
      5'h0F: count_o = CNT_W'(2);
      5'h13: count_o = CNT_W'(3);
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fdc_cmd_timer.sv
module fdc_cmd_timer #(
  parameter int unsigned PROC_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned TW = (PROC_CYC > 1) ? $clog2(PROC_CYC) : 1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!done_o)   cnt_q <= cnt_q + 1'b1;
    else                cnt_q <= '0;
  end

  assign done_o = run_i && (cnt_q == TW'(PROC_CYC - 1));
endmodule

// File: rtl/fdc_cmd_pstore.sv
module fdc_cmd_pstore #(
  parameter int unsigned MAX_PARAMS = 8,
  parameter int unsigned CNT_W      = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [CNT_W-1:0]        idx_i,
  input  logic [7:0]              data_i,
  output logic [MAX_PARAMS*8-1:0] params_o
);
  for (genvar g = 0; g < MAX_PARAMS; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q <= '0;
      else if (we_i && idx_i == CNT_W'(g))        slot_q <= data_i;
    end
    assign params_o[g*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_cmd_pkg::*;
#(
  parameter int unsigned MAX_PARAMS = 8,
  parameter int unsigned PROC_CYC   = 2,
  localparam int unsigned CNT_W     = $clog2(MAX_PARAMS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    soft_rst_i,
  input  logic                    wr_en_i,
  input  logic [7:0]              wr_data_i,
  input  logic                    rd_en_i,
  output logic [7:0]              rd_data_o,
  output logic [7:0]              msr_o,
  input  logic                    fifo_cfg_i,
  output logic                    fifo_en_o,
  output logic                    exec_start_o,
  output logic [7:0]              exec_opcode_o,
  output logic [CNT_W-1:0]        exec_nparam_o,
  output logic [MAX_PARAMS*8-1:0] exec_param_o,
  input  logic                    exec_done_i,
  input  logic [7:0]              exec_status_i
);
  phase_e           state_q;
  logic [7:0]       cmd_q, res_q;
  logic [CNT_W-1:0] idx_q, need_q;
  logic             first_q, start_q;
  logic             dec_valid, tmr_done, take_param, rqm, dio;
  logic [CNT_W-1:0] dec_cnt;

  fdc_cmd_decode #(.CNT_W(CNT_W)) u_decode (
    .code_i  (cmd_q[OPC_W-1:0]),
    .valid_o (dec_valid),
    .count_o (dec_cnt)
  );

  fdc_cmd_timer #(.PROC_CYC(PROC_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == PH_PROC && !soft_rst_i),
    .done_o (tmr_done)
  );

  assign take_param = wr_en_i && !soft_rst_i && state_q == PH_PARAM;

  fdc_cmd_pstore #(.MAX_PARAMS(MAX_PARAMS), .CNT_W(CNT_W)) u_pstore (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (take_param),
    .idx_i    (idx_q),
    .data_i   (wr_data_i),
    .params_o (exec_param_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_CMD;
      cmd_q   <= '0;
      res_q   <= '0;
      idx_q   <= '0;
      need_q  <= '0;
      first_q <= 1'b0;
      start_q <= 1'b0;
    end else if (soft_rst_i) begin
      state_q <= PH_CMD;
      idx_q   <= '0;
      need_q  <= '0;
      first_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        PH_CMD: if (wr_en_i) begin
          cmd_q   <= wr_data_i;
          idx_q   <= '0;
          first_q <= 1'b1;
          state_q <= PH_PROC;
        end
        PH_PARAM: if (wr_en_i) begin
          idx_q   <= idx_q + 1'b1;
          first_q <= 1'b0;
          state_q <= PH_PROC;
        end
        PH_PROC: if (tmr_done) begin
          if (first_q && !dec_valid) begin
            res_q   <= BAD_CMD_STATUS;
            state_q <= PH_RESULT;
          end else if (first_q && dec_cnt != '0) begin
            need_q  <= dec_cnt;
            state_q <= PH_PARAM;
          end else if (!first_q && idx_q != need_q) begin
            state_q <= PH_PARAM;
          end else begin
            start_q <= 1'b1;
            state_q <= PH_EXEC;
          end
        end
        PH_EXEC: if (exec_done_i) begin
          res_q   <= exec_status_i;
          state_q <= PH_RESULT;
        end
        PH_RESULT: if (rd_en_i) begin
          idx_q   <= '0;
          state_q <= PH_CMD;
        end
        default: state_q <= PH_CMD;
      endcase
    end
  end

  assign rqm           = state_q == PH_CMD || state_q == PH_PARAM || state_q == PH_RESULT;
  assign dio           = state_q == PH_RESULT;
  assign msr_o         = {rqm, dio, 1'b0, state_q != PH_CMD, 4'b0000};
  assign rd_data_o     = res_q;
  assign fifo_en_o     = fifo_cfg_i && state_q == PH_EXEC;
  assign exec_start_o  = start_q;
  assign exec_opcode_o = cmd_q;
  assign exec_nparam_o = idx_q;
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       wr_en_i,
  input logic [7:0] msr_o,
  input logic       fifo_en_o,
  input logic       exec_start_o
);
  logic acc;
  assign acc = wr_en_i && msr_o[7] && !msr_o[6] && !soft_rst_i;

  assert_rqm_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    acc |=> !msr_o[7]);

  assert_rqm_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    acc ##1 1'b1 |=> !msr_o[7]);

  assert_start_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |=> !exec_start_o);

  assert_start_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> msr_o == 8'h10);

  assert_fifo_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_o |-> msr_o == 8'h10);

  assert_dio_with_rqm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_o[6] |-> msr_o[7] && msr_o[4]);

  assert_soft_rst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> msr_o == 8'h80 && !exec_start_o);
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .wr_en_i      (wr_en_i),
  .msr_o        (msr_o),
  .fifo_en_o    (fifo_en_o),
  .exec_start_o (exec_start_o)
);

// File: tb/fdc_cmd_seq_tb.sv
module fdc_cmd_seq_tb_top;
  typedef logic [7:0] bq_t[$];
  typedef struct {
    logic [7:0]  op;
    logic [3:0]  n;
    logic [63:0] p;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic        fifo_cfg = 1'b0, exec_done = 1'b0;
  logic [7:0]  wr_data = '0, exec_status = '0;
  logic [7:0]  rd_data, msr, exec_op;
  logic        fifo_en, exec_start;
  logic [3:0]  exec_n;
  logic [63:0] exec_p;

  int checks = 0;
  int fails  = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  fdc_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .msr_o(msr), .fifo_cfg_i(fifo_cfg), .fifo_en_o(fifo_en),
    .exec_start_o(exec_start), .exec_opcode_o(exec_op), .exec_nparam_o(exec_n),
    .exec_param_o(exec_p), .exec_done_i(exec_done), .exec_status_i(exec_status)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] op, input bq_t prm);
    exp_t e;
    e.op = op; e.n = 4'(prm.size()); e.p = '0;
    for (int i = 0; i < prm.size(); i++) e.p[i*8 +: 8] = prm[i];
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && exec_start) begin
      if (exp_q.size() == 0) chk(1'b0, "R6_unexpected_handoff", {56'd0, exec_op}, 64'd0);
      else begin
        exp_t e;
        logic [63:0] mask;
        e = exp_q.pop_front();
        mask = '0;
        for (int i = 0; i < 8; i++) if (i < int'(e.n)) mask[i*8 +: 8] = 8'hFF;
        chk(exec_op == e.op, "R7_opcode", {56'd0, exec_op}, {56'd0, e.op});
        chk(exec_n == e.n, "R5_count", {60'd0, exec_n}, {60'd0, e.n});
        chk((exec_p & mask) == e.p, "R7_params", exec_p & mask, e.p);
        chk(msr == 8'h10, "R7_rqm_low", {56'd0, msr}, 64'h10);
      end
    end
  end

  task automatic wait_ready();
    for (int i = 0; i < 50; i++) begin
      if (msr[7] && !msr[6]) break;
      @(negedge clk);
    end
  endtask

  // complete=0: last byte is not final, RQM should come back
  task automatic send(input bq_t b, input bit complete, input bit inject);
    for (int i = 0; i < b.size(); i++) begin
      wait_ready();
      wr_en = 1'b1; wr_data = b[i];
      @(negedge clk);
      wr_en = 1'b0;
      chk(msr[7] == 1'b0, "R4_rqm_low_1", {63'd0, msr[7]}, 64'd0);
      if (inject) begin
        wr_en = 1'b1; wr_data = 8'hEE;
      end
      @(negedge clk);
      wr_en = 1'b0;
      chk(msr[7] == 1'b0, "R4_rqm_low_2", {63'd0, msr[7]}, 64'd0);
      @(negedge clk);
      if (i < b.size() - 1 || !complete)
        chk(msr == 8'h90, "R4_rqm_back", {56'd0, msr}, 64'h90);
      else
        chk(msr[7] == 1'b0, "R8_no_rqm_after_last", {63'd0, msr[7]}, 64'd0);
    end
  endtask

  task automatic finish_cmd(input logic [7:0] st);
    chk(msr == 8'h10, "R2_exec_msr", {56'd0, msr}, 64'h10);
    exec_done = 1'b1; exec_status = st;
    @(negedge clk);
    exec_done = 1'b0; exec_status = 8'h00;
    chk(msr == 8'hD0, "R10_result_msr", {56'd0, msr}, 64'hD0);
    chk(rd_data == st, "R10_result_byte", {56'd0, rd_data}, {56'd0, st});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(msr == 8'h80, "R10_back_to_cmd", {56'd0, msr}, 64'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(msr == 8'h80, "R1_msr", {56'd0, msr}, 64'h80);
    chk(!exec_start && !fifo_en, "R1_outputs", {62'd0, exec_start, fifo_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // two-argument code with FIFO configured on
    fifo_cfg = 1'b1;
    chk(fifo_en == 1'b0, "R9_fifo_off_cmd", {63'd0, fifo_en}, 64'd0);
    push_exp(8'h03, '{8'hAF, 8'h02});
    send('{8'h03, 8'hAF, 8'h02}, 1'b1, 1'b0);
    chk(fifo_en == 1'b1, "R9_fifo_on_exec", {63'd0, fifo_en}, 64'd1);
    finish_cmd(8'h20);

    // R3: write during processing is ignored
    push_exp(8'h0F, '{8'h01, 8'h40});
    send('{8'h0F, 8'h01, 8'h40}, 1'b1, 1'b1);
    finish_cmd(8'h00);

    // R3: write in result phase is ignored
    push_exp(8'h04, '{8'h03});
    send('{8'h04, 8'h03}, 1'b1, 1'b0);
    exec_done = 1'b1; exec_status = 8'h33;
    @(negedge clk);
    exec_done = 1'b0;
    wr_en = 1'b1; wr_data = 8'h08;
    @(negedge clk);
    wr_en = 1'b0;
    chk(msr == 8'hD0 && rd_data == 8'h33, "R3_ignored_in_result", {48'd0, msr, rd_data}, 64'hD033);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;

    // R12: modifier bits with eight arguments, FIFO off
    fifo_cfg = 1'b0;
    push_exp(8'hE6, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88});
    send('{8'hE6, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88}, 1'b1, 1'b0);
    chk(fifo_en == 1'b0, "R9_fifo_follows_cfg", {63'd0, fifo_en}, 64'd0);
    finish_cmd(8'h01);

    // R8: zero-argument codes
    push_exp(8'h08, '{});
    send('{8'h08}, 1'b1, 1'b0);
    finish_cmd(8'h02);
    push_exp(8'h8E, '{});
    send('{8'h8E}, 1'b1, 1'b0);
    finish_cmd(8'h03);

    // R6: invalid code
    wait_ready();
    wr_en = 1'b1; wr_data = 8'h1F;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk(msr == 8'h10, "R6_processing", {56'd0, msr}, 64'h10);
    @(negedge clk);
    chk(msr == 8'hD0, "R6_result_msr", {56'd0, msr}, 64'hD0);
    chk(rd_data == 8'h80, "R6_status", {56'd0, rd_data}, 64'h80);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(msr == 8'h80, "R6_back_to_cmd", {56'd0, msr}, 64'h80);

    // R11: soft reset mid-command
    send('{8'h0F, 8'h05}, 1'b0, 1'b0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(msr == 8'h80, "R11_soft_rst", {56'd0, msr}, 64'h80);
    push_exp(8'h07, '{8'h02});
    send('{8'h07, 8'h02}, 1'b1, 1'b0);
    finish_cmd(8'h04);

    // three-argument code
    push_exp(8'h13, '{8'h00, 8'h57, 8'h0C});
    send('{8'h13, 8'h00, 8'h57, 8'h0C}, 1'b1, 1'b0);
    finish_cmd(8'h05);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7_all_handoffs_seen", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule